// File: doc/BRIEF.md
# Squared-Current Trapezoidal Trip Integrator

This block builds a running Joule integral during a high-current short-circuit test. Each strobed current sample is squared. The trapezoid step then sums the new square with the square of the previous sample and halves that sum with a one-bit shift. The result goes into a wide saturating accumulator. Samples arrive at a fixed interval, so the total is kept in raw counts, and the consumer applies the constant time-step factor afterwards.

Every accumulator update is compared against a programmed limit. When the total reaches that limit, a latched trip output fires the thyristor gate driver within a few clock cycles of the strobe. A done flag follows one cycle later. An arm pulse starts each test: it clears the integral, the stored previous square and both latches. Samples that arrive before arming or after a trip do not change the total.

Top module: `joule_trip_integrator`

## Requirements
- R1: While reset is low, and after it is released, `acc_o` is 0 and `trip_o` and `done_o` are 0.
- R2: Each accepted sample s (16-bit two's complement) adds floor((s*s + p*p) / 2) to `acc_o`. Here p is the previously accepted sample.
- R3: For the first sample accepted after an arm pulse, p is taken as 0, so the step adds floor(s*s / 2).
- R4: A strobe captured at rising edge k appears in `acc_o` after edge k+2. Strobes on consecutive cycles are each integrated.
- R5: `trip_o` rises at the same edge at which `acc_o` first becomes greater than or equal to `limit_i` (unsigned compare). Equality trips.
- R6: `done_o` rises one cycle after `trip_o`. Both stay high until the next arm pulse.
- R7: Once `trip_o` is high, further samples, including those already in the pipeline, leave `acc_o` unchanged.
- R8: Samples are ignored before the first arm pulse. A sample strobed in the same cycle as `arm_i` is also ignored. The arm pulse clears `acc_o`, `trip_o`, `done_o` and the previous square at the edge that captures it.
- R9: `acc_o` saturates at 2^ACC_W-1 instead of wrapping. A saturated total with `limit_i` at all ones trips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm_i | input | 1 | One-cycle pulse that clears and starts a test |
| smp_valid_i | input | 1 | Sample strobe |
| smp_data_i | input | SAMPLE_W | Signed current sample |
| limit_i | input | ACC_W | Trip threshold in raw counts |
| acc_o | output | ACC_W | Running integral of the squared current |
| trip_o | output | 1 | Latched trip to the gate driver |
| done_o | output | 1 | Latched test-finished flag |

## Verification
A strobe captured at rising edge k loads the accumulator and the trip latch at edge k+2. The done flag follows at k+3, and an arm pulse takes effect at the very edge that captures it. The driver tags each expected result with the cycle count at which it falls due: three edges after the falling edge on which the sample was driven. The monitor compares at the falling edge of that cycle, so each value is read half a period after it settles. The done flag, the saturation case and the state after re-arming are read at the falling edge one cycle after the result they depend on.

// File: rtl/jt_pkg.sv
// Shared defaults and helpers for the Joule-integral trip block.
// Assumes callers size the accumulator at least as wide as a square.
package jt_pkg;
    localparam int SAMPLE_W_DEF = 16;
    localparam int ACC_W_DEF    = 56;

    // Width of the square of a SAMPLE_W-bit signed value
    function automatic int sq_width(input int sample_w);
        return 2 * sample_w;
    endfunction
endpackage

// File: rtl/jt_square.sv
// Stage 1: registers the square of an accepted signed sample.
// Assumes a flush (arm) drops any sample in flight.
module jt_square #(
    parameter int SAMPLE_W = 16,
    localparam int SQ_W = 2 * SAMPLE_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush_i,
    input  logic                       take_i,
    input  logic signed [SAMPLE_W-1:0] smp_i,
    output logic                       vld_o,
    output logic        [SQ_W-1:0]     sq_o
);
    logic signed [SQ_W-1:0] ext;
    logic signed [SQ_W-1:0] prod;

    // Sign-extend and square; the square of the most negative value still fits
    always_comb begin
        ext  = SQ_W'(smp_i);
        prod = ext * ext;
    end

    // Capture the square and its valid bit
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            vld_o <= 1'b0;
            sq_o  <= '0;
        end else begin
            vld_o <= take_i;
            if (take_i) sq_o <= $unsigned(prod);
        end
    end
endmodule

// File: rtl/jt_trap.sv
// Stage 2: trapezoid step, half of the current plus the previous square.
// Assumes the previous square is zero after a flush (first step of a test).
module jt_trap #(
    parameter int SQ_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush_i,
    input  logic            vld_i,
    input  logic [SQ_W-1:0] sq_i,
    output logic            vld_o,
    output logic [SQ_W-1:0] step_o
);
    logic [SQ_W-1:0] prev_q;
    logic [SQ_W:0]   pair_sum;

    // One extra bit so the sum of two squares cannot wrap before the shift
    always_comb pair_sum = {1'b0, sq_i} + {1'b0, prev_q};

    // Register the halved pair sum and remember the current square
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            vld_o  <= 1'b0;
            step_o <= '0;
            prev_q <= '0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                step_o <= pair_sum[SQ_W:1];
                prev_q <= sq_i;
            end
        end
    end
endmodule

// File: rtl/jt_accum.sv
// Stage 3: saturating accumulator, limit compare and trip/done latches.
// Assumes limit_i is held steady during a test; arm (flush) has priority.
module jt_accum #(
    parameter int ACC_W = 56,
    parameter int SQ_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             vld_i,
    input  logic [SQ_W-1:0]  step_i,
    input  logic [ACC_W-1:0] limit_i,
    output logic [ACC_W-1:0] acc_o,
    output logic             trip_o,
    output logic             done_o,
    output logic             open_o
);
    logic             armed_q;
    logic [ACC_W:0]   wide_sum;
    logic [ACC_W-1:0] acc_nxt;

    // Add with one guard bit and clamp to all ones on carry out
    always_comb begin
        wide_sum = {1'b0, acc_o} + (ACC_W + 1)'(step_i);
        acc_nxt  = wide_sum[ACC_W] ? {ACC_W{1'b1}} : wide_sum[ACC_W-1:0];
    end

    // Accept new samples only while armed and not yet tripped
    always_comb open_o = armed_q & ~trip_o;

    // Accumulate, compare against the limit and hold the latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_o   <= '0;
            trip_o  <= 1'b0;
            done_o  <= 1'b0;
            armed_q <= 1'b0;
        end else if (flush_i) begin
            acc_o   <= '0;
            trip_o  <= 1'b0;
            done_o  <= 1'b0;
            armed_q <= 1'b1;
        end else begin
            done_o <= trip_o;
            if (vld_i && !trip_o) begin
                acc_o <= acc_nxt;
                if (acc_nxt >= limit_i) trip_o <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/joule_trip_integrator.sv
// Top: integrates the squared current point by point and trips on a limit.
// Assumes a fixed sample interval; time-step scaling is left to the consumer.
module joule_trip_integrator #(
    parameter int SAMPLE_W = jt_pkg::SAMPLE_W_DEF,
    parameter int ACC_W    = jt_pkg::ACC_W_DEF,
    localparam int SQ_W    = jt_pkg::sq_width(SAMPLE_W)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       arm_i,
    input  logic                       smp_valid_i,
    input  logic signed [SAMPLE_W-1:0] smp_data_i,
    input  logic        [ACC_W-1:0]    limit_i,
    output logic        [ACC_W-1:0]    acc_o,
    output logic                       trip_o,
    output logic                       done_o
);
    logic            take;
    logic            open_w;
    logic            s1_vld;
    logic [SQ_W-1:0] s1_sq;
    logic            s2_vld;
    logic [SQ_W-1:0] s2_step;

    // A sample enters only when armed, not tripped, and not during an arm pulse
    always_comb take = smp_valid_i & open_w & ~arm_i;

    jt_square #(.SAMPLE_W(SAMPLE_W)) u_sq (
        .clk(clk), .rst_n(rst_n), .flush_i(arm_i), .take_i(take),
        .smp_i(smp_data_i), .vld_o(s1_vld), .sq_o(s1_sq)
    );

    jt_trap #(.SQ_W(SQ_W)) u_trap (
        .clk(clk), .rst_n(rst_n), .flush_i(arm_i), .vld_i(s1_vld),
        .sq_i(s1_sq), .vld_o(s2_vld), .step_o(s2_step)
    );

    jt_accum #(.ACC_W(ACC_W), .SQ_W(SQ_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .flush_i(arm_i), .vld_i(s2_vld),
        .step_i(s2_step), .limit_i(limit_i), .acc_o(acc_o),
        .trip_o(trip_o), .done_o(done_o), .open_o(open_w)
    );
endmodule

// File: rtl/jt_checker.sv
// Property checker bound to the top; observes ports only.
module jt_checker #(
    parameter int ACC_W = 56
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arm_i,
    input logic             smp_valid_i,
    input logic [ACC_W-1:0] limit_i,
    input logic [ACC_W-1:0] acc_o,
    input logic             trip_o,
    input logic             done_o
);
    AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> (acc_o == '0 && !trip_o && !done_o)); // R8

    AST_TRIP_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trip_o) |-> acc_o >= $past(limit_i)); // R5

    AST_TRIP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_o && !arm_i) |=> trip_o); // R6

    AST_DONE_LAGS: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_i |=> done_o == $past(trip_o)); // R6

    AST_FROZEN_AFTER_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_o && !arm_i) |=> $stable(acc_o)); // R7

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_i |=> acc_o >= $past(acc_o)); // R9

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_o != $past(acc_o) && !$past(arm_i)) |-> $past(smp_valid_i, 3)); // R4
endmodule

bind joule_trip_integrator jt_checker #(.ACC_W(ACC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .smp_valid_i(smp_valid_i),
    .limit_i(limit_i), .acc_o(acc_o), .trip_o(trip_o), .done_o(done_o)
);

// File: tb/sim_joule_trip_integrator.sv
`timescale 1ns/1ps
module sim_joule_trip_integrator;
    localparam int AW  = 56;
    localparam int AW1 = 34;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arm = 1'b0;
    logic vld = 1'b0;
    logic signed [15:0] dat = '0;
    logic [AW-1:0] limit = '1;
    logic [AW-1:0] acc;
    logic trip, done;
    logic arm1 = 1'b0;
    logic [AW1-1:0] acc1;
    logic trip1, done1;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    joule_trip_integrator u0 (
        .clk(clk), .rst_n(rst_n), .arm_i(arm), .smp_valid_i(vld),
        .smp_data_i(dat), .limit_i(limit), .acc_o(acc), .trip_o(trip), .done_o(done)
    );

    joule_trip_integrator #(.ACC_W(AW1)) u1 (
        .clk(clk), .rst_n(rst_n), .arm_i(arm1), .smp_valid_i(vld),
        .smp_data_i(dat), .limit_i({AW1{1'b1}}), .acc_o(acc1), .trip_o(trip1), .done_o(done1)
    );

    // Reference model state, derived from the requirements
    logic [AW-1:0]     m_acc = '0;
    longint unsigned   m_prev = 0;
    bit                m_trip = 1'b0;
    bit                m_armed = 1'b0;

    // Scoreboard queues
    int            due_q[$];
    logic [AW-1:0] acc_q[$];
    bit            trip_q[$];
    string         tag_q[$];

    task automatic check(input bit ok, input string tag, input longint unsigned act,
                         input longint unsigned exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Driver: drive one sample, update the model, push the expected result
    task automatic send(input logic signed [15:0] d, input string tag);
        longint unsigned sq, half;
        logic [AW:0] s;
        @(negedge clk);
        vld = 1'b1;
        dat = d;
        if (m_armed && !m_trip) begin
            sq = longint'(d) * longint'(d);
            half = (sq + m_prev) >> 1;
            m_prev = sq;
            s = {1'b0, m_acc} + (AW + 1)'(half);
            m_acc = s[AW] ? {AW{1'b1}} : s[AW-1:0];
            if (m_acc >= limit) m_trip = 1'b1;
        end
        due_q.push_back(cyc + 3);
        acc_q.push_back(m_acc);
        trip_q.push_back(m_trip);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            vld = 1'b0;
            arm = 1'b0;
        end
    endtask

    task automatic do_arm(input logic [AW-1:0] lim);
        idle(5);
        limit = lim;
        @(negedge clk);
        arm = 1'b1;
        m_acc = '0; m_prev = 0; m_trip = 1'b0; m_armed = 1'b1;
        @(negedge clk);
        arm = 1'b0;
    endtask

    // Monitor: pop and compare each item at the cycle it falls due
    always @(negedge clk) begin
        while (due_q.size() > 0 && due_q[0] == cyc) begin
            check(acc === acc_q[0], {tag_q[0], " acc"}, acc, acc_q[0]);
            check(trip === trip_q[0], {tag_q[0], " trip"}, trip, trip_q[0]);
            void'(due_q.pop_front());
            void'(acc_q.pop_front());
            void'(trip_q.pop_front());
            void'(tag_q.pop_front());
        end
    end

    // Watchdog
    initial begin
        #(5.0 * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(acc == 0 && !trip && !done, "R1 in reset", acc, 0);
        rst_n = 1'b1;
        idle(2);
        check(acc == 0 && !trip && !done, "R1 after reset", acc, 0);

        // Unarmed samples are ignored
        send(16'sd1000, "R8 unarmed");
        send(-16'sd5000, "R8 unarmed");
        idle(5);

        // Main integration, back to back, mixed signs and extremes
        do_arm(56'd1_000_000_000_000);
        send(16'sd100, "R3 first sample");
        send(-16'sd200, "R2 step");
        send(16'sd300, "R2 R4 back-to-back");
        send(16'sd32767, "R2 full positive");
        send(-16'sh8000, "R2 full negative");
        send(16'sd0, "R2 zero");
        idle(2);
        send(16'sd7, "R2 after gap");
        send(16'sd7, "R4 repeat");
        idle(5);

        // Equality trips on the first sample
        do_arm(56'd5000);
        send(16'sd100, "R5 equal limit");
        idle(5);
        check(done === 1'b1, "R6 done after equal trip", done, 1);

        // Re-arm clears latches
        do_arm(56'd20_000_000);
        check(acc == 0 && !trip && !done, "R8 re-arm clears", acc, 0);
        send(16'sd3000, "R3 first after re-arm");
        send(16'sd3000, "R5 below limit");
        send(16'sd3000, "R5 crossing");
        send(16'sd3000, "R7 in-flight ignored");
        send(-16'sd3000, "R7 ignored");
        idle(1);
        // trip due at negedge after the crossing sample: check done one cycle later
        wait (due_q.size() == 0);
        check(trip === 1'b1, "R6 trip held", trip, 1);
        check(done === 1'b1, "R6 done held", done, 1);
        idle(3);
        check(acc == 64'd22_500_000, "R7 frozen value", acc, 22_500_000);

        // Sample coincident with arm is ignored
        idle(5);
        limit = '1;
        @(negedge clk);
        arm = 1'b1; vld = 1'b1; dat = 16'sd4000;
        m_acc = '0; m_prev = 0; m_trip = 1'b0; m_armed = 1'b1;
        due_q.push_back(cyc + 3); acc_q.push_back('0); trip_q.push_back(1'b0);
        tag_q.push_back("R8 sample with arm");
        idle(1);
        send(16'sd10, "R3 prev zero after ignored sample");
        idle(6);

        // Saturation on the narrow instance
        @(negedge clk);
        arm1 = 1'b1;
        @(negedge clk);
        arm1 = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            vld = 1'b1; dat = -16'sh8000;
        end
        idle(6);
        check(acc1 == {AW1{1'b1}}, "R9 saturated", acc1, {AW1{1'b1}});
        check(trip1 === 1'b1 && done1 === 1'b1, "R9 trip at all-ones limit", trip1, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule